// File: doc/BRIEF.md
# TLB Invalidation Engine

This block keeps a small unified translation buffer and carries out invalidation commands against it. Each entry stores a valid flag, a lock flag, a global flag, an 8-bit address-space identifier (ASID) and a 20-bit virtual page number. Commands arrive on a write-only port as a target selector, an operation code and a 32-bit operand. Three kinds of invalidation exist, and each treats locked and global entries by its own rule.

Two of the operations finish in one clock. The ASID sweep walks the buffer one entry per cycle. An interrupt request can cut the sweep short. The block then reports that the command did not execute, and a later reissue restarts the walk from entry 0. A fill port loads entries. The valid flags of all entries are visible on an output vector, so the effect of each command can be observed at the ports.

Top module: `tlb_inval_engine`

## Requirements
- R1: The target selector `cmd_target` accepts 1 (instruction), 2 (data) and 3 (unified), and all three act on the same single buffer. Target 0 is reserved and is treated as an illegal access.
- R2: Operation code 0 clears the valid flag of every entry whose lock flag is 0. Locked entries stay valid.
- R3: An accepted operation 0 raises `pf_flush` for exactly the one cycle after the accepting clock edge. Operations 1 and 2 never raise it.
- R4: Operation code 1 reads the page number from operand bits [31:12] and the ASID from bits [7:0]. It clears every entry whose page number matches and that is either global or has a matching ASID. Lock flags are ignored.
- R5: Operation code 2 takes the ASID from operand bits [7:0]. It clears every non-global entry with that ASID, locked or not, and leaves global entries valid.
- R6: Operation 2 checks entry k at the (k+1)-th clock edge after the accepting edge. `busy` is high for exactly ENTRIES cycles, starting in the cycle after acceptance.
- R7: When `irq` is high at an edge while `busy` is high, the sweep stops at that edge and leaves the current and later entries untouched. `busy` falls and `not_exec` pulses for one cycle. When `busy` is low, `irq` has no effect.
- R8: Reissuing operation 2 after an interruption restarts at entry 0. An entry with that ASID that was filled after the interruption is cleared.
- R9: A command with `cmd_write`=0, with `cmd_priv`=0, with target 0 or with operation code 3 raises `undef_acc` for one cycle after the edge and changes no entry.
- R10: While `busy` is high, every command, legal or not, is ignored. It changes no entry and raises neither `undef_acc` nor `pf_flush`.
- R11: Operations 0 and 1 and fills take effect at the accepting edge, and `valid_vec` shows the new state in the following cycle.
- R12: A fill and a sweep clear of the same entry at the same edge leave the newly filled entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_write | input | 1 | 1 = write, 0 = read attempt |
| cmd_priv | input | 1 | 1 = privileged mode |
| cmd_target | input | 2 | 1 instruction, 2 data, 3 unified, 0 reserved |
| cmd_op | input | 2 | 0 all unlocked, 1 by page, 2 by ASID, 3 reserved |
| cmd_operand | input | 32 | Page number [31:12], ASID [7:0] |
| irq | input | 1 | Interrupt request |
| fill_valid | input | 1 | Fill strobe |
| fill_idx | input | IDX_W | Entry to fill |
| fill_vpn | input | 20 | Page number of the filled entry |
| fill_asid | input | 8 | ASID of the filled entry |
| fill_global | input | 1 | Global flag of the filled entry |
| fill_lock | input | 1 | Lock flag of the filled entry |
| busy | output | 1 | ASID sweep in progress |
| undef_acc | output | 1 | Illegal access pulse |
| pf_flush | output | 1 | Prefetch flush request pulse |
| not_exec | output | 1 | Interrupted command pulse |
| valid_vec | output | ENTRIES | Valid flag of each entry |

## Verification
Two events can meet at one clock edge: a fill and a sweep clear aimed at the same entry. The bench provokes this by timing the fill of entry 2 so that it lands on the edge at which the sweep checks entry 2. The fill is judged to win when `valid_vec` bit 2 is still set after the sweep ends. The bench also lets an interrupt land in the middle of a sweep. It then confirms that only the entries before that edge were cleared, and that a restart also removes an entry filled in between.

// File: rtl/tlbi_pkg.sv
package tlbi_pkg;

    localparam int ASID_W = 8;
    localparam int VPN_W  = 20;

    typedef enum logic [1:0] {
        OP_ALL_UNLOCKED = 2'd0,
        OP_BY_PAGE      = 2'd1,
        OP_BY_ASID      = 2'd2,
        OP_RSVD         = 2'd3
    } tlbi_op_e;

    typedef enum logic [1:0] {
        TGT_NONE    = 2'd0,
        TGT_INSTR   = 2'd1,
        TGT_DATA    = 2'd2,
        TGT_UNIFIED = 2'd3
    } tlbi_tgt_e;

    typedef struct packed {
        logic              valid;
        logic              lock;
        logic              glob;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
    } tlb_entry_t;

    typedef struct packed {
        logic clr_unlocked;
        logic clr_page;
        logic start_sweep;
        logic illegal;
    } tlbi_req_t;

    function automatic logic [VPN_W-1:0] operand_vpn(input logic [31:0] opnd);
        return opnd[31:12];
    endfunction

    function automatic logic [ASID_W-1:0] operand_asid(input logic [31:0] opnd);
        return opnd[ASID_W-1:0];
    endfunction

endpackage

// File: rtl/tlbi_cmd_decode.sv
module tlbi_cmd_decode
    import tlbi_pkg::*;
(
    input  logic      cmd_valid,
    input  logic      cmd_write,
    input  logic      cmd_priv,
    input  logic [1:0] cmd_target,
    input  logic [1:0] cmd_op,
    input  logic      busy,
    output tlbi_req_t req
);
    logic      accept;
    logic      legal;
    tlbi_op_e  op;
    tlbi_tgt_e tgt;

    always_comb begin
        op     = tlbi_op_e'(cmd_op);
        tgt    = tlbi_tgt_e'(cmd_target);
        accept = cmd_valid && !busy;
        legal  = cmd_write && cmd_priv && (tgt != TGT_NONE) && (op != OP_RSVD);
        req.illegal      = accept && !legal;
        req.clr_unlocked = accept && legal && (op == OP_ALL_UNLOCKED);
        req.clr_page     = accept && legal && (op == OP_BY_PAGE);
        req.start_sweep  = accept && legal && (op == OP_BY_ASID);
    end
endmodule

// File: rtl/tlbi_sweep_ctrl.sv
module tlbi_sweep_ctrl
    import tlbi_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ASID_W-1:0] start_asid,
    input  logic              irq,
    output logic              busy,
    output logic              check,
    output logic [IDX_W-1:0]  idx,
    output logic [ASID_W-1:0] sweep_asid,
    output logic              not_exec
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    assign check = busy && !irq;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy       <= 1'b0;
            idx        <= '0;
            sweep_asid <= '0;
            not_exec   <= 1'b0;
        end else begin
            not_exec <= 1'b0;
            if (start) begin
                busy       <= 1'b1;
                idx        <= '0;
                sweep_asid <= start_asid;
            end else if (busy) begin
                if (irq) begin
                    busy     <= 1'b0;
                    not_exec <= 1'b1;
                end else if (idx == LAST) begin
                    busy <= 1'b0;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tlbi_entry_array.sv
module tlbi_entry_array
    import tlbi_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_unlocked,
    input  logic              clr_page,
    input  logic [VPN_W-1:0]  page_vpn,
    input  logic [ASID_W-1:0] page_asid,
    input  logic              sweep_chk,
    input  logic [IDX_W-1:0]  sweep_idx,
    input  logic [ASID_W-1:0] sweep_asid,
    input  logic              fill_valid,
    input  logic [IDX_W-1:0]  fill_idx,
    input  tlb_entry_t        fill_entry,
    output logic [ENTRIES-1:0] valid_vec
);
    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        tlb_entry_t ent;
        logic       page_hit;
        logic       sweep_hit;
        logic       kill;

        always_comb begin
            page_hit  = ent.valid && (ent.vpn == page_vpn) &&
                        (ent.glob || (ent.asid == page_asid));
            sweep_hit = sweep_chk && (sweep_idx == IDX_W'(g)) &&
                        !ent.glob && (ent.asid == sweep_asid);
            kill      = (clr_unlocked && !ent.lock) ||
                        (clr_page && page_hit) || sweep_hit;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                ent <= '0;
            end else if (fill_valid && (fill_idx == IDX_W'(g))) begin
                ent <= fill_entry;
            end else if (kill) begin
                ent.valid <= 1'b0;
            end
        end

        assign valid_vec[g] = ent.valid;
    end
endmodule

// File: rtl/tlb_inval_engine.sv
module tlb_inval_engine
    import tlbi_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W = $clog2(ENTRIES)
)(
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic               cmd_write,
    input  logic               cmd_priv,
    input  logic [1:0]         cmd_target,
    input  logic [1:0]         cmd_op,
    input  logic [31:0]        cmd_operand,
    input  logic               irq,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [19:0]        fill_vpn,
    input  logic [7:0]         fill_asid,
    input  logic               fill_global,
    input  logic               fill_lock,
    output logic               busy,
    output logic               undef_acc,
    output logic               pf_flush,
    output logic               not_exec,
    output logic [ENTRIES-1:0] valid_vec
);
    tlbi_req_t         req;
    tlb_entry_t        fill_entry;
    logic              sweep_chk;
    logic [IDX_W-1:0]  sweep_idx;
    logic [ASID_W-1:0] sweep_asid;

    tlbi_cmd_decode u_dec (
        .cmd_valid (cmd_valid),
        .cmd_write (cmd_write),
        .cmd_priv  (cmd_priv),
        .cmd_target(cmd_target),
        .cmd_op    (cmd_op),
        .busy      (busy),
        .req       (req)
    );

    tlbi_sweep_ctrl #(.ENTRIES(ENTRIES)) u_sweep (
        .clk       (clk),
        .rst       (rst),
        .start     (req.start_sweep),
        .start_asid(operand_asid(cmd_operand)),
        .irq       (irq),
        .busy      (busy),
        .check     (sweep_chk),
        .idx       (sweep_idx),
        .sweep_asid(sweep_asid),
        .not_exec  (not_exec)
    );

    always_comb begin
        fill_entry.valid = 1'b1;
        fill_entry.lock  = fill_lock;
        fill_entry.glob  = fill_global;
        fill_entry.asid  = fill_asid;
        fill_entry.vpn   = fill_vpn;
    end

    tlbi_entry_array #(.ENTRIES(ENTRIES)) u_arr (
        .clk         (clk),
        .rst         (rst),
        .clr_unlocked(req.clr_unlocked),
        .clr_page    (req.clr_page),
        .page_vpn    (operand_vpn(cmd_operand)),
        .page_asid   (operand_asid(cmd_operand)),
        .sweep_chk   (sweep_chk),
        .sweep_idx   (sweep_idx),
        .sweep_asid  (sweep_asid),
        .fill_valid  (fill_valid),
        .fill_idx    (fill_idx),
        .fill_entry  (fill_entry),
        .valid_vec   (valid_vec)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            undef_acc <= 1'b0;
            pf_flush  <= 1'b0;
        end else begin
            undef_acc <= req.illegal;
            pf_flush  <= req.clr_unlocked;
        end
    end
endmodule

// File: rtl/tlbi_checker.sv
module tlbi_checker #(
    parameter int ENTRIES = 8
)(
    input logic               clk,
    input logic               rst,
    input logic               cmd_valid,
    input logic               irq,
    input logic               fill_valid,
    input logic               busy,
    input logic               undef_acc,
    input logic               pf_flush,
    input logic               not_exec,
    input logic [ENTRIES-1:0] valid_vec
);
    logic [15:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst || !busy) busy_run <= '0;
        else              busy_run <= busy_run + 16'd1;
    end

    // R6
    sweep_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (busy_run < 16'(ENTRIES)));

    // R6
    sweep_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid));

    // R7
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
        not_exec |-> ($past(busy) && $past(irq) && !busy));

    // R3
    flush_src_chk: assert property (@(posedge clk) disable iff (rst)
        pf_flush |-> $past(cmd_valid && !busy));

    // R9
    undef_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (undef_acc && !$past(fill_valid)) |-> (valid_vec == $past(valid_vec)));

    // R10
    undef_flush_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(undef_acc && pf_flush));
endmodule

bind tlb_inval_engine tlbi_checker #(.ENTRIES(ENTRIES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .irq       (irq),
    .fill_valid(fill_valid),
    .busy      (busy),
    .undef_acc (undef_acc),
    .pf_flush  (pf_flush),
    .not_exec  (not_exec),
    .valid_vec (valid_vec)
);

// File: tb/sim_tlb_inval_engine.sv
module sim_tlb_inval_engine;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 0, cmd_write = 0, cmd_priv = 0;
    logic [1:0]  cmd_target = 0, cmd_op = 0;
    logic [31:0] cmd_operand = 0;
    logic        irq = 0;
    logic        fill_valid = 0;
    logic [2:0]  fill_idx = 0;
    logic [19:0] fill_vpn = 0;
    logic [7:0]  fill_asid = 0;
    logic        fill_global = 0, fill_lock = 0;
    logic        busy, undef_acc, pf_flush, not_exec;
    logic [N-1:0] valid_vec;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_inval_engine #(.ENTRIES(N)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
        .cmd_priv(cmd_priv), .cmd_target(cmd_target), .cmd_op(cmd_op),
        .cmd_operand(cmd_operand), .irq(irq), .fill_valid(fill_valid),
        .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
        .fill_global(fill_global), .fill_lock(fill_lock), .busy(busy),
        .undef_acc(undef_acc), .pf_flush(pf_flush), .not_exec(not_exec),
        .valid_vec(valid_vec)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            failures++;
            $display("FAIL watchdog: act=%0d exp<=50000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic fill(input int idx, input logic [19:0] vpn, input logic [7:0] asid,
                        input logic g, input logic l);
        @(negedge clk);
        fill_valid = 1; fill_idx = 3'(idx); fill_vpn = vpn;
        fill_asid = asid; fill_global = g; fill_lock = l;
        @(negedge clk);
        fill_valid = 0;
    endtask

    task automatic issue(input logic wr, input logic pr, input logic [1:0] tgt,
                         input logic [1:0] op, input logic [31:0] opnd);
        @(negedge clk);
        cmd_valid = 1; cmd_write = wr; cmd_priv = pr;
        cmd_target = tgt; cmd_op = op; cmd_operand = opnd;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    // idx 0..3 ASID 5, 4..7 ASID 9; locked 1,4; global 3,6; page = 0x100+idx
    task automatic load_set();
        for (int i = 0; i < N; i++)
            fill(i, 20'h100 + 20'(i), (i < 4) ? 8'd5 : 8'd9, (i == 3 || i == 6), (i == 1 || i == 4));
    endtask

    function automatic logic [31:0] page_opnd(input logic [19:0] vpn, input logic [7:0] asid);
        return {vpn, 4'b0, asid};
    endfunction

    task automatic t_reset();
        chk("R11 reset valid_vec", 32'(valid_vec), 0);
        chk("R6 reset busy", 32'(busy), 0);
        chk("R9 reset undef_acc", 32'(undef_acc), 0);
        chk("R3 reset pf_flush", 32'(pf_flush), 0);
    endtask

    task automatic t_all_unlocked();
        load_set();
        chk("R11 fill visible", 32'(valid_vec), 32'hFF);
        issue(1, 1, 2'd1, 2'd0, 0);
        chk("R2 locked entries kept", 32'(valid_vec), 32'h12);
        chk("R3 flush pulse", 32'(pf_flush), 1);
        @(negedge clk);
        chk("R3 flush one cycle", 32'(pf_flush), 0);
    endtask

    task automatic t_targets();
        load_set();
        issue(1, 1, 2'd2, 2'd1, page_opnd(20'h105, 8'd9));
        chk("R1 data target hits unified", 32'(valid_vec), 32'hDF);
        chk("R3 no flush for op1", 32'(pf_flush), 0);
        issue(1, 1, 2'd3, 2'd1, page_opnd(20'h100, 8'd5));
        chk("R1 unified target", 32'(valid_vec), 32'hDE);
    endtask

    task automatic t_by_page();
        load_set();
        issue(1, 1, 2'd3, 2'd1, page_opnd(20'h101, 8'd5));
        chk("R4 locked page cleared", 32'(valid_vec), 32'hFD);
        issue(1, 1, 2'd3, 2'd1, page_opnd(20'h103, 8'h77));
        chk("R4 global page any ASID", 32'(valid_vec), 32'hF5);
        issue(1, 1, 2'd3, 2'd1, page_opnd(20'h104, 8'd5));
        chk("R4 ASID mismatch kept", 32'(valid_vec), 32'hF5);
    endtask

    task automatic t_by_asid();
        load_set();
        issue(1, 1, 2'd3, 2'd2, 32'd5);
        chk("R6 busy after accept", 32'(busy), 1);
        repeat (N - 1) @(negedge clk);
        chk("R6 busy through last entry", 32'(busy), 1);
        @(negedge clk);
        chk("R6 busy low after sweep", 32'(busy), 0);
        chk("R5 ASID sweep result", 32'(valid_vec), 32'hF8);
        chk("R7 no abort", 32'(not_exec), 0);
    endtask

    task automatic t_refuse_busy();
        load_set();
        issue(1, 1, 2'd3, 2'd2, 32'd9);
        issue(1, 1, 2'd1, 2'd0, 0);
        chk("R10 no flush while busy", 32'(pf_flush), 0);
        issue(0, 0, 2'd0, 2'd3, 0);
        chk("R10 no undef while busy", 32'(undef_acc), 0);
        repeat (N - 2) @(negedge clk);
        chk("R10 sweep done", 32'(busy), 0);
        chk("R10 refused op0 left entries", 32'(valid_vec), 32'h4F);
    endtask

    task automatic t_undef();
        load_set();
        issue(0, 1, 2'd3, 2'd0, 0);
        chk("R9 read undef", 32'(undef_acc), 1);
        chk("R9 read no change", 32'(valid_vec), 32'hFF);
        issue(1, 0, 2'd3, 2'd0, 0);
        chk("R9 user undef", 32'(undef_acc), 1);
        chk("R9 user no flush", 32'(pf_flush), 0);
        issue(1, 1, 2'd0, 2'd0, 0);
        chk("R1 reserved target undef", 32'(undef_acc), 1);
        issue(1, 1, 2'd3, 2'd3, 0);
        chk("R9 reserved op undef", 32'(undef_acc), 1);
        chk("R9 entries unchanged", 32'(valid_vec), 32'hFF);
        @(negedge clk);
        chk("R9 undef one cycle", 32'(undef_acc), 0);
    endtask

    task automatic t_interrupt();
        for (int i = 0; i < N; i++) fill(i, 20'h200 + 20'(i), 8'd5, 0, 0);
        @(negedge clk); irq = 1;
        @(negedge clk); irq = 0;
        chk("R7 idle irq no effect", 32'(not_exec), 0);
        issue(1, 1, 2'd3, 2'd2, 32'd5);
        repeat (3) @(negedge clk);
        chk("R7 partial sweep", 32'(valid_vec), 32'hF8);
        irq = 1;
        @(negedge clk);
        irq = 0;
        chk("R7 busy drops", 32'(busy), 0);
        chk("R7 not_exec pulse", 32'(not_exec), 1);
        chk("R7 rest untouched", 32'(valid_vec), 32'hF8);
        @(negedge clk);
        chk("R7 not_exec one cycle", 32'(not_exec), 0);
        fill(0, 20'h2AA, 8'd5, 0, 0);
        chk("R8 refill visible", 32'(valid_vec), 32'hF9);
        issue(1, 1, 2'd3, 2'd2, 32'd5);
        repeat (N) @(negedge clk);
        chk("R8 restart clears refill", 32'(valid_vec), 32'h00);
        chk("R8 restart completes", 32'(busy), 0);
    endtask

    task automatic t_collide();
        load_set();
        issue(1, 1, 2'd3, 2'd2, 32'd5);
        @(negedge clk);
        @(negedge clk);
        fill_valid = 1; fill_idx = 3'd2; fill_vpn = 20'h1AA;
        fill_asid = 8'd5; fill_global = 0; fill_lock = 0;
        @(negedge clk);
        fill_valid = 0;
        chk("R12 fill beats sweep clear", 32'(valid_vec[2]), 1);
        repeat (N - 3) @(negedge clk);
        chk("R12 sweep ended", 32'(busy), 0);
        chk("R12 final state", 32'(valid_vec), 32'hFC);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_all_unlocked();
        t_targets();
        t_by_page();
        t_by_asid();
        t_refuse_busy();
        t_undef();
        t_interrupt();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule